// File: doc/BRIEF.md
# Synchronous Burst Cache RAM Cycle Controller

This block is the command front end and storage of a synchronous burst cache RAM. On every rising clock edge it samples an address, a write word, two active-low address strobes, an advance input, three chip enables and the write controls. It turns them into one of five actions: stay idle, deselect, begin a new access at the external address, step to the next burst address, or repeat the current address. The word is 72 bits, made of eight 9-bit byte lanes. Writes go only to the lanes the write controls select. Reads return the addressed word on a separate output port, together with a drive-enable flag that stands for the tri-state bus.

Two static inputs choose the wrap order of the four-word burst (linear or interleaved) and the read path. In the flow-through path the read word comes straight from the array. In the pipelined path it passes through an output register and shows one clock later. An active-low output enable gates the drive flag directly, with no clock involved.

Top module: `bsram_ctrl`

## Requirements
- R1: A cycle begins a new access at `addr_i` when a strobe is taken and the chip is enabled, meaning `cs1_n`=0, `cs2`=1 and `cs3_n`=0. The enables matter only in cycles where a strobe is low.
- R2: `ctrl_strb_n` low with any enable inactive deselects the device. With `pipe_en`=0 the bus is off after the next edge. While deselected, cycles with both strobes high read and write nothing.
- R3: `proc_strb_n` low with `cs1_n`=0 takes precedence over `ctrl_strb_n`. It deselects if `cs2`=0 or `cs3_n`=1. `proc_strb_n` low with `cs1_n`=1 is ignored, so the cycle behaves as if that strobe were high.
- R4: An access begun through `proc_strb_n` is always a read and never changes the array, whatever the write inputs are.
- R5: `allwr_n`=0 writes all eight lanes. Otherwise `wr_n`=0 writes only the lanes whose `lane_wr_n` bit is 0. Lane k occupies bits [9k+8:9k], so lane 0 is bits [8:0]. When no lane is selected the cycle is a read.
- R6: With both strobes high on a selected device, `step_n`=0 moves to the next burst address and `step_n`=1 repeats the current one. For start offset s in the low two address bits, the k-th step gives (s+k) mod 4 when `seq_ilv`=0 and s XOR k when `seq_ilv`=1. The upper address bits stay fixed.
- R7: Each step or repeat cycle chooses read or write afresh from that cycle's write inputs.
- R8: With `pipe_en`=0, a read's word appears after the edge that registers it. With `pipe_en`=1, it appears one edge later.
- R9: `out_en_n`=1 clears `dq_oe_o` at once, without a clock. The bus is not driven for write cycles.
- R10: After reset the device is deselected, `dq_oe_o`=0, and `rdata_o` reads zero whenever `dq_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | AW | Word address, low two bits are the burst offset |
| wdata_i | input | 72 | Write word, eight 9-bit lanes |
| proc_strb_n | input | 1 | Processor-side address strobe, active low |
| ctrl_strb_n | input | 1 | Controller-side address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| cs1_n | input | 1 | Primary chip enable, active low |
| cs2 | input | 1 | Depth-expansion enable, active high |
| cs3_n | input | 1 | Depth-expansion enable, active low |
| allwr_n | input | 1 | Write all lanes, active low |
| wr_n | input | 1 | Lane-selected write enable, active low |
| lane_wr_n | input | 8 | Per-lane write selects, active low |
| seq_ilv | input | 1 | Static burst order: 0 linear, 1 interleaved |
| pipe_en | input | 1 | Static read path: 0 flow-through, 1 pipelined |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| rdata_o | output | 72 | Read word, zero when not driven |
| dq_oe_o | output | 1 | Bus drive enable |

## Verification
The bench builds the block with a 64-word array and the default eight 9-bit lanes. At that depth it can fill every word with a known pattern first, so each random read, in both wrap orders, lands on data the scoreboard already knows. Since the read path is a static input and not a parameter, one build covers both the flow-through and the pipelined path, each after its own reset. Random traffic mixes both strobes, disabled chips, ignored strobes and partial-lane writes over the small address space. This brings deselect-then-continue runs and block wrap-around into reach many times over.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    localparam int NUM_LANES  = 8;
    localparam int LANE_BITS  = 9;
    localparam int BURST_LEN  = 4;
    localparam int BURST_BITS = $clog2(BURST_LEN);

    typedef enum logic [2:0] {
        CMD_IDLE,
        CMD_DESEL,
        CMD_BEGIN,
        CMD_STEP,
        CMD_HOLD
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e kind;
        logic      is_wr;
    } cmd_t;

    typedef struct packed {
        logic en1_n;
        logic en2;
        logic en3_n;
    } chip_en_t;

    // Offset within the burst block after 'step' advances from 'start'
    function automatic logic [BURST_BITS-1:0] burst_offset(
        input logic [BURST_BITS-1:0] start,
        input logic [BURST_BITS-1:0] step,
        input logic                  ilv
    );
        return ilv ? (start ^ step) : (start + step);
    endfunction

    function automatic logic enables_ok(input chip_en_t e);
        return !e.en1_n && e.en2 && !e.en3_n;
    endfunction

endpackage

// File: rtl/bsram_decode.sv
module bsram_decode import bsram_pkg::*; #(
    parameter int LANES = NUM_LANES
) (
    input  logic             proc_strb_n,
    input  logic             ctrl_strb_n,
    input  logic             step_n,
    input  chip_en_t         en,
    input  logic             allwr_n,
    input  logic             wr_n,
    input  logic [LANES-1:0] lane_wr_n,
    input  logic             sel_q,
    output cmd_t             cmd,
    output logic [LANES-1:0] lane_we
);

    logic [LANES-1:0] mask;

    // Global write overrides the lane-selected write
    always_comb begin
        if (!allwr_n)   mask = '1;
        else if (!wr_n) mask = ~lane_wr_n;
        else            mask = '0;
    end

    always_comb begin
        cmd.kind  = CMD_IDLE;
        cmd.is_wr = 1'b0;
        lane_we   = '0;
        if (!proc_strb_n && !en.en1_n) begin
            // processor-side start is read-only
            cmd.kind = enables_ok(en) ? CMD_BEGIN : CMD_DESEL;
        end else if (!ctrl_strb_n) begin
            if (enables_ok(en)) begin
                cmd.kind  = CMD_BEGIN;
                cmd.is_wr = |mask;
                lane_we   = mask;
            end else begin
                cmd.kind = CMD_DESEL;
            end
        end else if (sel_q) begin
            cmd.kind  = step_n ? CMD_HOLD : CMD_STEP;
            cmd.is_wr = |mask;
            lane_we   = mask;
        end
    end

endmodule

// File: rtl/bsram_burst_seq.sv
module bsram_burst_seq import bsram_pkg::*; #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  cmd_t          cmd,
    input  logic [AW-1:0] addr_i,
    input  logic          ilv,
    output logic          acc_en,
    output logic [AW-1:0] acc_addr,
    output logic [AW-1:0] acc_q,
    output logic          sel_q,
    output logic          rd_q
);

    logic [AW-1:0]         base_q;
    logic [BURST_BITS-1:0] cnt_q;
    logic [BURST_BITS-1:0] cnt_d;

    always_comb begin
        cnt_d    = cnt_q;
        acc_addr = acc_q;
        acc_en   = 1'b0;
        unique case (cmd.kind)
            CMD_BEGIN: begin
                cnt_d    = '0;
                acc_addr = addr_i;
                acc_en   = 1'b1;
            end
            CMD_STEP: begin
                cnt_d    = cnt_q + BURST_BITS'(1);
                acc_addr = {base_q[AW-1:BURST_BITS],
                            burst_offset(base_q[BURST_BITS-1:0], cnt_d, ilv)};
                acc_en   = 1'b1;
            end
            CMD_HOLD: begin
                acc_en = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cnt_q  <= '0;
            acc_q  <= '0;
            sel_q  <= 1'b0;
            rd_q   <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            if (cmd.kind == CMD_BEGIN) begin
                base_q <= addr_i;
                sel_q  <= 1'b1;
            end else if (cmd.kind == CMD_DESEL) begin
                sel_q <= 1'b0;
            end
            if (acc_en) acc_q <= acc_addr;
            rd_q <= acc_en && !cmd.is_wr;
        end
    end

endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
    parameter int LANES  = 8,
    parameter int LANE_W = 9,
    parameter int DEPTH  = 256,
    localparam int AW     = $clog2(DEPTH),
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic [LANES-1:0]  lane_we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (lane_we[g]) cells[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = cells[raddr];
    end

endmodule

// File: rtl/bsram_rdpath.sv
module bsram_rdpath #(
    parameter int W = 72
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pipe_en,
    input  logic         rd_q,
    input  logic         out_en_n,
    input  logic [W-1:0] array_data,
    output logic [W-1:0] rdata_o,
    output logic         dq_oe_o
);

    logic [W-1:0] hold_q;
    logic         hold_v_q;
    logic [W-1:0] stage_d;
    logic         stage_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q   <= '0;
            hold_v_q <= 1'b0;
        end else begin
            hold_v_q <= rd_q;
            if (rd_q) hold_q <= array_data;
        end
    end

    assign stage_v = pipe_en ? hold_v_q : rd_q;
    assign stage_d = pipe_en ? hold_q   : array_data;
    assign dq_oe_o = stage_v && !out_en_n;
    assign rdata_o = dq_oe_o ? stage_d : '0;

endmodule

// File: rtl/bsram_ctrl.sv
module bsram_ctrl import bsram_pkg::*; #(
    parameter int LANES  = NUM_LANES,
    parameter int LANE_W = LANE_BITS,
    parameter int DEPTH  = 256,
    localparam int AW     = $clog2(DEPTH),
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic              proc_strb_n,
    input  logic              ctrl_strb_n,
    input  logic              step_n,
    input  logic              cs1_n,
    input  logic              cs2,
    input  logic              cs3_n,
    input  logic              allwr_n,
    input  logic              wr_n,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic              seq_ilv,
    input  logic              pipe_en,
    input  logic              out_en_n,
    output logic [WORD_W-1:0] rdata_o,
    output logic              dq_oe_o
);

    chip_en_t          en;
    cmd_t              cmd;
    cmd_kind_e         cmd_kind;
    logic [LANES-1:0]  lane_we;
    logic [LANES-1:0]  wr_lanes;
    logic              sel_q;
    logic              rd_q;
    logic              acc_en;
    logic [AW-1:0]     acc_addr;
    logic [AW-1:0]     acc_q;
    logic [WORD_W-1:0] arr_rd;

    assign en       = {cs1_n, cs2, cs3_n};
    assign cmd_kind = cmd.kind;
    assign wr_lanes = (acc_en && cmd.is_wr) ? lane_we : '0;

    bsram_decode #(.LANES(LANES)) u_decode (
        .proc_strb_n (proc_strb_n),
        .ctrl_strb_n (ctrl_strb_n),
        .step_n      (step_n),
        .en          (en),
        .allwr_n     (allwr_n),
        .wr_n        (wr_n),
        .lane_wr_n   (lane_wr_n),
        .sel_q       (sel_q),
        .cmd         (cmd),
        .lane_we     (lane_we)
    );

    bsram_burst_seq #(.AW(AW)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .addr_i   (addr_i),
        .ilv      (seq_ilv),
        .acc_en   (acc_en),
        .acc_addr (acc_addr),
        .acc_q    (acc_q),
        .sel_q    (sel_q),
        .rd_q     (rd_q)
    );

    bsram_array #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH)) u_array (
        .clk     (clk),
        .lane_we (wr_lanes),
        .waddr   (acc_addr),
        .wdata   (wdata_i),
        .raddr   (acc_q),
        .rdata   (arr_rd)
    );

    bsram_rdpath #(.W(WORD_W)) u_rdpath (
        .clk        (clk),
        .rst        (rst),
        .pipe_en    (pipe_en),
        .rd_q       (rd_q),
        .out_en_n   (out_en_n),
        .array_data (arr_rd),
        .rdata_o    (rdata_o),
        .dq_oe_o    (dq_oe_o)
    );

endmodule

// File: rtl/bsram_ctrl_chk.sv
module bsram_ctrl_chk import bsram_pkg::*; #(
    parameter int AW    = 8,
    parameter int LANES = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             proc_strb_n,
    input logic             ctrl_strb_n,
    input logic             cs1_n,
    input logic             cs2,
    input logic             cs3_n,
    input logic             allwr_n,
    input logic             pipe_en,
    input logic             out_en_n,
    input logic             dq_oe_o,
    input logic             sel_q,
    input logic             rd_q,
    input logic             acc_en,
    input logic [AW-1:0]    acc_q,
    input logic [LANES-1:0] wr_lanes,
    input cmd_kind_e        kind
);

    logic bad_en;
    logic proc_take;
    assign bad_en    = cs1_n || !cs2 || cs3_n;
    assign proc_take = !proc_strb_n && !cs1_n;

    AST_OE_GATES_BUS: assert property (@(posedge clk) disable iff (rst)
        out_en_n |-> !dq_oe_o); // R9
    AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (!pipe_en && (|wr_lanes)) |=> !dq_oe_o); // R9
    AST_CTRL_DESELECT: assert property (@(posedge clk) disable iff (rst)
        (!pipe_en && !ctrl_strb_n && bad_en && !proc_take) |=> !dq_oe_o); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!sel_q && proc_strb_n && ctrl_strb_n) |-> (wr_lanes == '0)); // R2
    AST_PROC_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
        proc_take |-> (wr_lanes == '0)); // R4
    AST_GLOBAL_ALL_LANES: assert property (@(posedge clk) disable iff (rst)
        (acc_en && !allwr_n && !proc_take) |-> (&wr_lanes)); // R5
    AST_HOLD_SAME_ADDR: assert property (@(posedge clk) disable iff (rst)
        (kind == CMD_HOLD) |=> $stable(acc_q)); // R6
    AST_PIPE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (pipe_en && rd_q) |=> (out_en_n || dq_oe_o)); // R8

endmodule

bind bsram_ctrl bsram_ctrl_chk #(.AW(AW), .LANES(LANES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .proc_strb_n (proc_strb_n),
    .ctrl_strb_n (ctrl_strb_n),
    .cs1_n       (cs1_n),
    .cs2         (cs2),
    .cs3_n       (cs3_n),
    .allwr_n     (allwr_n),
    .pipe_en     (pipe_en),
    .out_en_n    (out_en_n),
    .dq_oe_o     (dq_oe_o),
    .sel_q       (sel_q),
    .rd_q        (rd_q),
    .acc_en      (acc_en),
    .acc_q       (acc_q),
    .wr_lanes    (wr_lanes),
    .kind        (cmd_kind)
);

// File: tb/bsram_ctrl_tb.sv
module bsram_ctrl_tb;

    localparam int LANES = 8;
    localparam int LW    = 9;
    localparam int W     = LANES * LW;
    localparam int DEPTH = 64;
    localparam int AW    = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [AW-1:0]    i_addr;
    logic [W-1:0]     i_wdata;
    logic             i_proc_n, i_ctrl_n, i_step_n;
    logic             i_en1_n, i_en2, i_en3_n;
    logic             i_allwr_n, i_wr_n;
    logic [LANES-1:0] i_lane_n;
    logic             i_ilv, i_pipe, i_oe_n;
    logic [W-1:0]     rdata_o;
    logic             dq_oe_o;

    bsram_ctrl #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .addr_i(i_addr), .wdata_i(i_wdata),
        .proc_strb_n(i_proc_n), .ctrl_strb_n(i_ctrl_n), .step_n(i_step_n),
        .cs1_n(i_en1_n), .cs2(i_en2), .cs3_n(i_en3_n),
        .allwr_n(i_allwr_n), .wr_n(i_wr_n), .lane_wr_n(i_lane_n),
        .seq_ilv(i_ilv), .pipe_en(i_pipe), .out_en_n(i_oe_n),
        .rdata_o(rdata_o), .dq_oe_o(dq_oe_o)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Scoreboard
    logic [W-1:0]  mm [DEPTH];
    logic          m_sel, m_rd, m_pdrv;
    logic [AW-1:0] m_base, m_acc;
    logic [1:0]    m_cnt;
    logic [W-1:0]  m_pdat;

    function automatic logic [W-1:0] pat(input int a);
        logic [W-1:0] v;
        for (int k = 0; k < LANES; k++) v[k*LW +: LW] = 9'(a * 13 + k * 29 + 5);
        return v;
    endfunction

    task automatic chk(input string tag, input logic [W:0] got, input logic [W:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [W:0] expect_out();
        logic         d;
        logic [W-1:0] v;
        d = (i_pipe ? m_pdrv : m_rd) && !i_oe_n;
        v = i_pipe ? m_pdat : mm[m_acc];
        return d ? {1'b1, v} : {1'b0, {W{1'b0}}};
    endfunction

    task automatic mstep();
        logic             ok, wr, acc;
        logic [LANES-1:0] msk;
        logic [AW-1:0]    a;
        logic [1:0]       off;
        ok = !i_en1_n && i_en2 && !i_en3_n;
        if (!i_allwr_n)   msk = '1;
        else if (!i_wr_n) msk = ~i_lane_n;
        else              msk = '0;
        wr = (msk != 0);
        m_pdrv = m_rd;
        if (m_rd) m_pdat = mm[m_acc];
        acc = 1'b0;
        a   = m_acc;
        if (!i_proc_n && !i_en1_n) begin
            if (ok) begin
                m_sel = 1'b1; m_base = i_addr; m_cnt = 2'd0; a = i_addr; acc = 1'b1; wr = 1'b0;
            end else m_sel = 1'b0;
        end else if (!i_ctrl_n) begin
            if (ok) begin
                m_sel = 1'b1; m_base = i_addr; m_cnt = 2'd0; a = i_addr; acc = 1'b1;
            end else m_sel = 1'b0;
        end else if (m_sel) begin
            acc = 1'b1;
            if (!i_step_n) begin
                m_cnt = m_cnt + 2'd1;
                off   = i_ilv ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
                a     = {m_base[AW-1:2], off};
            end
        end
        if (acc && wr)
            for (int k = 0; k < LANES; k++)
                if (msk[k]) mm[a][k*LW +: LW] = i_wdata[k*LW +: LW];
        if (acc) m_acc = a;
        m_rd = acc && !wr;
    endtask

    task automatic cyc(input string tag);
        @(posedge clk);
        mstep();
        @(negedge clk);
        chk(tag, {dq_oe_o, rdata_o}, expect_out());
    endtask

    task automatic idle_in();
        i_proc_n = 1'b1; i_ctrl_n = 1'b1; i_step_n = 1'b1;
        i_en1_n = 1'b0; i_en2 = 1'b1; i_en3_n = 1'b0;
        i_allwr_n = 1'b1; i_wr_n = 1'b1; i_lane_n = '1;
        i_oe_n = 1'b0;
    endtask

    task automatic do_reset(input logic pipe);
        idle_in();
        i_ilv = 1'b0; i_pipe = pipe; i_addr = '0; i_wdata = '0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_sel = 1'b0; m_rd = 1'b0; m_pdrv = 1'b0; m_acc = '0; m_base = '0; m_cnt = '0; m_pdat = '0;
        chk("R10 reset state", {dq_oe_o, rdata_o}, {1'b0, {W{1'b0}}});
    endtask

    task automatic proc_read(input int a, input string tag);
        idle_in(); i_proc_n = 1'b0; i_addr = AW'(a);
        cyc(tag);
        idle_in();
    endtask

    task automatic run_mode(input logic pipe);
        do_reset(pipe);
        // Fill every word through global-write bursts
        for (int b = 0; b < DEPTH; b += 4) begin
            idle_in(); i_ctrl_n = 1'b0; i_allwr_n = 1'b0; i_addr = AW'(b); i_wdata = pat(b);
            cyc("R5 global write begin");
            for (int k = 1; k < 4; k++) begin
                idle_in(); i_step_n = 1'b0; i_allwr_n = 1'b0; i_wdata = pat(b + k);
                cyc("R9 bus off while writing");
            end
        end
        idle_in(); i_ctrl_n = 1'b0; i_en2 = 1'b0;
        cyc("R2 controller strobe deselect");
        idle_in(); i_step_n = 1'b0; i_allwr_n = 1'b0; i_wdata = '1;
        cyc("R2 no access while deselected");
        // Linear then interleaved burst from offset 2
        for (int o = 0; o < 2; o++) begin
            i_ilv = o[0];
            proc_read(6, "R1 begin read");
            for (int k = 0; k < 3; k++) begin
                idle_in(); i_step_n = 1'b0;
                cyc(o == 0 ? "R6 linear step" : "R6 interleaved step");
            end
            idle_in();
            cyc("R6 hold");
            cyc("R8 read latency");
        end
        i_ilv = 1'b0;
        // Processor strobe with write inputs stays a read
        idle_in(); i_proc_n = 1'b0; i_addr = AW'(9); i_allwr_n = 1'b0; i_wdata = '1;
        cyc("R4 processor start reads");
        idle_in();
        cyc("R4 hold");
        chk("R4 word unchanged", {dq_oe_o, rdata_o}, {1'b1, pat(9)});
        // Lane 0 only
        idle_in(); i_ctrl_n = 1'b0; i_addr = AW'(12); i_wr_n = 1'b0; i_lane_n = 8'hFE; i_wdata = '1;
        cyc("R5 lane write");
        proc_read(12, "R5 read back");
        cyc("R5 hold");
        chk("R5 lane 0 only", {dq_oe_o, rdata_o}, {1'b1, pat(12)[W-1:LW], 9'h1FF});
        // No lane selected is a read
        idle_in(); i_ctrl_n = 1'b0; i_addr = AW'(13); i_lane_n = 8'h00; i_wdata = '1;
        cyc("R5 no lane is read");
        idle_in();
        cyc("R5 hold");
        chk("R5 word unchanged", {dq_oe_o, rdata_o}, {1'b1, pat(13)});
        // Per-cycle read/write choice inside a burst
        idle_in(); i_ctrl_n = 1'b0; i_addr = AW'(16); i_allwr_n = 1'b0; i_wdata = pat(100);
        cyc("R7 write begin");
        idle_in(); i_step_n = 1'b0;
        cyc("R7 read step");
        idle_in(); i_step_n = 1'b0; i_wr_n = 1'b0; i_lane_n = 8'h7F; i_wdata = pat(101);
        cyc("R7 write step");
        idle_in(); i_step_n = 1'b0;
        cyc("R7 read step");
        idle_in();
        cyc("R7 hold");
        // Ignored and deselecting processor strobe
        proc_read(20, "R1 begin read");
        idle_in(); i_proc_n = 1'b0; i_en1_n = 1'b1; i_step_n = 1'b0;
        cyc("R3 ignored strobe steps");
        idle_in();
        cyc("R3 hold");
        chk("R3 ignored strobe address", {dq_oe_o, rdata_o}, {1'b1, pat(21)});
        idle_in(); i_proc_n = 1'b0; i_en3_n = 1'b1; i_ctrl_n = 1'b0;
        cyc("R3 processor strobe deselect");
        idle_in(); i_step_n = 1'b0; i_allwr_n = 1'b0; i_wdata = '1;
        cyc("R3 deselected");
        cyc("R2 still deselected");
        proc_read(22, "R2 data kept");
        cyc("R2 hold");
        chk("R2 no write while deselected", {dq_oe_o, rdata_o}, {1'b1, pat(22)});
        // Asynchronous output enable
        proc_read(24, "R9 read");
        cyc("R9 hold");
        i_oe_n = 1'b1; #1;
        chk("R9 async disable", {dq_oe_o, rdata_o}, {1'b0, {W{1'b0}}});
        i_oe_n = 1'b0; #1;
        chk("R9 async enable", {dq_oe_o, rdata_o}, {1'b1, pat(24)});
        // Random traffic
        for (int n = 0; n < 3000; n++) begin
            i_proc_n  = ($urandom % 8) != 0;
            i_ctrl_n  = ($urandom % 8) != 0;
            i_step_n  = $urandom % 2;
            i_en1_n   = ($urandom % 6) == 0;
            i_en2     = ($urandom % 6) != 0;
            i_en3_n   = ($urandom % 6) == 0;
            i_allwr_n = ($urandom % 8) != 0;
            i_wr_n    = ($urandom % 3) != 0;
            i_lane_n  = LANES'($urandom);
            i_addr    = AW'($urandom);
            i_wdata   = {$urandom, $urandom, $urandom};
            i_oe_n    = ($urandom % 4) == 0;
            if (n == 1500) i_ilv = 1'b1;
            cyc("R8 random traffic");
        end
    endtask

    initial begin
        void'($urandom(32'd7321));
        run_mode(1'b0);
        run_mode(1'b1);
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule